// File: doc/BRIEF.md
# Message packetizer and phit link adapter

This block connects a processing core to an on-chip network link. On the transmit side the core hands over a message descriptor (destination column, destination row, a user tag and a word count) with a valid/ready handshake. It then supplies the payload as a stream of 32-bit words. The block forms a packet. Its first flit is a header built from the descriptor, and one payload flit follows for each word. Every flit is cut into phits, and the phits leave on the link under a per-phit valid/ready handshake.

The receive side takes phits from a link, rebuilds whole flits and strips the packet framing. It gives the core a one-cycle header pulse that carries the descriptor fields. Each payload word then arrives with its own valid pulse, and an end-of-message flag marks the final item of the message. The core never sees flit or phit boundaries.

The parameter `PHITS_PER_FLIT` selects one or two phits per flit. The default, which the requirements below describe, is two 16-bit phits per flit.

Top module: `na_adapter`

## Requirements
- R1: During and right after reset, `tx_msg_ready` is 1, and `tx_phit_valid`, `rx_hdr_valid`, `rx_word_valid` and `rx_eom` are 0. A reset in the middle of a packet returns the block to this state.
- R2: The header flit carries destination column in bits [31:28], destination row in bits [27:24], the user tag in bits [23:16] and the payload word count in bits [15:0].
- R3: Each flit leaves as two 16-bit phits, with flit bits [15:0] first and bits [31:16] second. A packet with N payload words therefore uses exactly 2*(N+1) phit transfers.
- R4: Payload words appear on the link in the order the core supplied them, right after the header flit.
- R5: From the cycle a message descriptor is accepted until the last phit of that packet has been taken by the link, `tx_msg_ready` stays 0.
- R6: A message with word count 0 produces a header flit only. On the receive side, `rx_eom` is raised together with `rx_hdr_valid`, and no `rx_word_valid` pulse follows.
- R7: For each received packet, `rx_hdr_valid` pulses for one cycle, never in the same cycle as `rx_word_valid`. `rx_dst_x`, `rx_dst_y`, `rx_user` and `rx_len` equal the transmitted header fields.
- R8: The receiver delivers exactly the word count given in the header, in order, and raises `rx_eom` only with the final word.
- R9: While `tx_phit_valid` is 1 and `tx_phit_ready` is 0, the phit data and valid stay unchanged. Link stalls lose and duplicate nothing.
- R10: The receiver presents a rebuilt flit only once its second phit has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_msg_valid | input | 1 | Message descriptor offered |
| tx_msg_ready | output | 1 | Descriptor accepted when high with valid |
| tx_dst_x | input | 4 | Destination column |
| tx_dst_y | input | 4 | Destination row |
| tx_user | input | 8 | User tag |
| tx_len | input | 16 | Payload length in words |
| tx_word_valid | input | 1 | Payload word offered |
| tx_word_ready | output | 1 | Payload word taken |
| tx_word | input | 32 | Payload word |
| tx_phit_valid | output | 1 | Outgoing phit valid |
| tx_phit_ready | input | 1 | Link takes the outgoing phit |
| tx_phit | output | 32/PHITS_PER_FLIT | Outgoing phit data |
| rx_phit_valid | input | 1 | Incoming phit valid |
| rx_phit_ready | output | 1 | Incoming phit taken |
| rx_phit | input | 32/PHITS_PER_FLIT | Incoming phit data |
| rx_hdr_valid | output | 1 | One-cycle pulse: header fields valid |
| rx_dst_x | output | 4 | Received destination column |
| rx_dst_y | output | 4 | Received destination row |
| rx_user | output | 8 | Received user tag |
| rx_len | output | 16 | Received word count |
| rx_word_valid | output | 1 | One-cycle pulse: payload word valid |
| rx_word | output | 32 | Received payload word |
| rx_eom | output | 1 | Final item of the message |

## Verification
A wrong remaining-word count in the transmit path shows as a phit total that misses 2*(N+1). It also keeps `tx_msg_ready` low too long or drops it too early, and that is visible within the packet in question. A swapped or stuck half-select in either converter corrupts the very first header phit pair. The decoded header fields then come out wrong within a few cycles of the packet start. A receive counter that is off by one moves `rx_eom` onto the wrong word, or leaves the next header to be read as payload, so the fault appears at the next message boundary. Running part of the traffic with periodic link stalls shows whether a held phit is lost or sent twice.

// File: rtl/na_pkg.sv
package na_pkg;

    localparam int FLIT_W  = 32;
    localparam int WORD_W  = 32;
    localparam int LEN_W   = 16;
    localparam int USER_W  = 8;
    localparam int COORD_W = 4;

    // Header flit layout: MSB first, so dst_x lands in [31:28]
    typedef struct packed {
        logic [COORD_W-1:0] dst_x;
        logic [COORD_W-1:0] dst_y;
        logic [USER_W-1:0]  user;
        logic [LEN_W-1:0]   len;
    } na_hdr_t;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_HDR  = 2'd1,
        PK_PAY  = 2'd2
    } pk_state_t;

    typedef enum logic {
        DP_HDR = 1'b0,
        DP_PAY = 1'b1
    } dp_state_t;

    function automatic logic is_final(input logic [LEN_W-1:0] remain);
        return remain == LEN_W'(1);
    endfunction

endpackage

// File: rtl/na_packetizer.sv
module na_packetizer
    import na_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    output logic              msg_ready,
    input  na_hdr_t           msg_hdr,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word,
    input  logic              ser_idle,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [FLIT_W-1:0] flit
);

    pk_state_t         state;
    na_hdr_t           hdr_q;
    logic [LEN_W-1:0]  remain;

    assign msg_ready = (state == PK_IDLE) && ser_idle;

    always_comb begin
        flit_valid = 1'b0;
        flit       = '0;
        word_ready = 1'b0;
        case (state)
            PK_HDR: begin
                flit_valid = 1'b1;
                flit       = hdr_q;
            end
            PK_PAY: begin
                flit_valid = word_valid;
                flit       = word;
                word_ready = flit_ready;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PK_IDLE;
            hdr_q  <= '0;
            remain <= '0;
        end else begin
            case (state)
                PK_IDLE: if (msg_valid && msg_ready) begin
                    hdr_q  <= msg_hdr;
                    remain <= msg_hdr.len;
                    state  <= PK_HDR;
                end
                PK_HDR: if (flit_ready) begin
                    state <= (remain == '0) ? PK_IDLE : PK_PAY;
                end
                PK_PAY: if (word_valid && flit_ready) begin
                    remain <= remain - LEN_W'(1);
                    if (is_final(remain)) state <= PK_IDLE;
                end
                default: state <= PK_IDLE;
            endcase
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_ready |=> !msg_ready); // R5

endmodule

// File: rtl/na_phit_ser.sv
module na_phit_ser
    import na_pkg::*;
#(
    parameter int PHITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flit_valid,
    output logic                    flit_ready,
    input  logic [FLIT_W-1:0]       flit,
    output logic                    phit_valid,
    input  logic                    phit_ready,
    output logic [FLIT_W/PHITS-1:0] phit,
    output logic                    idle
);

    localparam int PHIT_W = FLIT_W / PHITS;
    localparam int IDX_W  = (PHITS > 1) ? $clog2(PHITS) : 1;

    logic              busy;
    logic [FLIT_W-1:0] hold;
    logic [IDX_W-1:0]  idx;
    logic [PHIT_W-1:0] slice [PHITS];
    logic              last;

    for (genvar g = 0; g < PHITS; g++) begin : g_slice
        assign slice[g] = hold[g*PHIT_W +: PHIT_W];
    end

    assign last       = (idx == IDX_W'(PHITS - 1));
    assign phit_valid = busy;
    assign phit       = slice[idx];
    assign flit_ready = !busy || (phit_ready && last);
    assign idle       = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            hold <= '0;
            idx  <= '0;
        end else if (flit_valid && flit_ready) begin
            busy <= 1'b1;
            hold <= flit;
            idx  <= '0;
        end else if (busy && phit_ready) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + IDX_W'(1);
        end
    end

    AST_PHIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        phit_valid && !phit_ready |=> phit_valid && $stable(phit)); // R9

endmodule

// File: rtl/na_phit_deser.sv
module na_phit_deser
    import na_pkg::*;
#(
    parameter int PHITS = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    phit_valid,
    output logic                    phit_ready,
    input  logic [FLIT_W/PHITS-1:0] phit,
    output logic                    flit_valid,
    input  logic                    flit_ready,
    output logic [FLIT_W-1:0]       flit
);

    localparam int PHIT_W = FLIT_W / PHITS;
    localparam int IDX_W  = (PHITS > 1) ? $clog2(PHITS) : 1;

    logic              full;
    logic [IDX_W-1:0]  idx;
    logic [PHIT_W-1:0] part [PHITS];
    logic              last;

    for (genvar g = 0; g < PHITS; g++) begin : g_join
        assign flit[g*PHIT_W +: PHIT_W] = part[g];
    end

    assign last       = (idx == IDX_W'(PHITS - 1));
    assign phit_ready = !full;
    assign flit_valid = full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            idx  <= '0;
            for (int k = 0; k < PHITS; k++) part[k] <= '0;
        end else begin
            if (full && flit_ready) full <= 1'b0;
            if (phit_valid && phit_ready) begin
                part[idx] <= phit;
                if (last) begin
                    full <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    AST_FLIT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(flit_valid) |-> $past(phit_valid && phit_ready && last)); // R10

endmodule

// File: rtl/na_depacketizer.sv
module na_depacketizer
    import na_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               flit_valid,
    output logic               flit_ready,
    input  logic [FLIT_W-1:0]  flit,
    output logic               hdr_valid,
    output na_hdr_t            hdr,
    output logic               word_valid,
    output logic [WORD_W-1:0]  word,
    output logic               eom
);

    dp_state_t        state;
    logic [LEN_W-1:0] remain;
    na_hdr_t          in_hdr;

    assign flit_ready = 1'b1;
    assign in_hdr     = na_hdr_t'(flit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= DP_HDR;
            remain     <= '0;
            hdr_valid  <= 1'b0;
            hdr        <= '0;
            word_valid <= 1'b0;
            word       <= '0;
            eom        <= 1'b0;
        end else begin
            hdr_valid  <= 1'b0;
            word_valid <= 1'b0;
            eom        <= 1'b0;
            if (flit_valid) begin
                if (state == DP_HDR) begin
                    hdr_valid <= 1'b1;
                    hdr       <= in_hdr;
                    remain    <= in_hdr.len;
                    eom       <= (in_hdr.len == '0);
                    if (in_hdr.len != '0) state <= DP_PAY;
                end else begin
                    word_valid <= 1'b1;
                    word       <= flit;
                    eom        <= is_final(remain);
                    remain     <= remain - LEN_W'(1);
                    if (is_final(remain)) state <= DP_HDR;
                end
            end
        end
    end

    AST_HDR_WORD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(hdr_valid && word_valid)); // R7

    AST_EOM_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        eom |-> (word_valid || (hdr_valid && hdr.len == '0))); // R8

endmodule

// File: rtl/na_adapter.sv
module na_adapter
    import na_pkg::*;
#(
    parameter int PHITS_PER_FLIT = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tx_msg_valid,
    output logic                             tx_msg_ready,
    input  logic [3:0]                       tx_dst_x,
    input  logic [3:0]                       tx_dst_y,
    input  logic [7:0]                       tx_user,
    input  logic [15:0]                      tx_len,
    input  logic                             tx_word_valid,
    output logic                             tx_word_ready,
    input  logic [31:0]                      tx_word,
    output logic                             tx_phit_valid,
    input  logic                             tx_phit_ready,
    output logic [32/PHITS_PER_FLIT-1:0]     tx_phit,
    input  logic                             rx_phit_valid,
    output logic                             rx_phit_ready,
    input  logic [32/PHITS_PER_FLIT-1:0]     rx_phit,
    output logic                             rx_hdr_valid,
    output logic [3:0]                       rx_dst_x,
    output logic [3:0]                       rx_dst_y,
    output logic [7:0]                       rx_user,
    output logic [15:0]                      rx_len,
    output logic                             rx_word_valid,
    output logic [31:0]                      rx_word,
    output logic                             rx_eom
);

    na_hdr_t           tx_hdr;
    na_hdr_t           rx_hdr;
    logic              ser_idle;
    logic              txf_valid, txf_ready;
    logic [FLIT_W-1:0] txf;
    logic              rxf_valid, rxf_ready;
    logic [FLIT_W-1:0] rxf;

    assign tx_hdr = '{dst_x: tx_dst_x, dst_y: tx_dst_y, user: tx_user, len: tx_len};

    na_packetizer u_pack (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (tx_msg_valid),
        .msg_ready  (tx_msg_ready),
        .msg_hdr    (tx_hdr),
        .word_valid (tx_word_valid),
        .word_ready (tx_word_ready),
        .word       (tx_word),
        .ser_idle   (ser_idle),
        .flit_valid (txf_valid),
        .flit_ready (txf_ready),
        .flit       (txf)
    );

    na_phit_ser #(.PHITS(PHITS_PER_FLIT)) u_ser (
        .clk        (clk),
        .rst        (rst),
        .flit_valid (txf_valid),
        .flit_ready (txf_ready),
        .flit       (txf),
        .phit_valid (tx_phit_valid),
        .phit_ready (tx_phit_ready),
        .phit       (tx_phit),
        .idle       (ser_idle)
    );

    na_phit_deser #(.PHITS(PHITS_PER_FLIT)) u_deser (
        .clk        (clk),
        .rst        (rst),
        .phit_valid (rx_phit_valid),
        .phit_ready (rx_phit_ready),
        .phit       (rx_phit),
        .flit_valid (rxf_valid),
        .flit_ready (rxf_ready),
        .flit       (rxf)
    );

    na_depacketizer u_depack (
        .clk        (clk),
        .rst        (rst),
        .flit_valid (rxf_valid),
        .flit_ready (rxf_ready),
        .flit       (rxf),
        .hdr_valid  (rx_hdr_valid),
        .hdr        (rx_hdr),
        .word_valid (rx_word_valid),
        .word       (rx_word),
        .eom        (rx_eom)
    );

    assign rx_dst_x = rx_hdr.dst_x;
    assign rx_dst_y = rx_hdr.dst_y;
    assign rx_user  = rx_hdr.user;
    assign rx_len   = rx_hdr.len;

    AST_IDLE_TX_QUIET: assert property (@(posedge clk) disable iff (rst)
        tx_msg_ready |-> !tx_phit_valid); // R5

endmodule

// File: tb/na_adapter_tb.sv
module na_adapter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_msg_valid = 1'b0;
    logic        tx_msg_ready;
    logic [3:0]  tx_dst_x = '0, tx_dst_y = '0;
    logic [7:0]  tx_user = '0;
    logic [15:0] tx_len = '0;
    logic        tx_word_valid = 1'b0;
    logic        tx_word_ready;
    logic [31:0] tx_word = '0;
    logic        tx_phit_valid, tx_phit_ready;
    logic [15:0] tx_phit;
    logic        rx_phit_valid, rx_phit_ready;
    logic [15:0] rx_phit;
    logic        rx_hdr_valid, rx_word_valid, rx_eom;
    logic [3:0]  rx_dst_x, rx_dst_y;
    logic [7:0]  rx_user;
    logic [15:0] rx_len;
    logic [31:0] rx_word;

    always #10 clk = ~clk;

    // link loopback with optional periodic stall
    logic       stall_en = 1'b0;
    logic [1:0] scnt = '0;
    logic       stall;
    always @(posedge clk) scnt <= (scnt == 2'd2) ? 2'd0 : scnt + 2'd1;
    assign stall         = stall_en && (scnt == 2'd1);
    assign rx_phit_valid = tx_phit_valid && !stall;
    assign tx_phit_ready = rx_phit_ready && !stall;
    assign rx_phit       = tx_phit;

    na_adapter u_dut (
        .clk(clk), .rst(rst),
        .tx_msg_valid(tx_msg_valid), .tx_msg_ready(tx_msg_ready),
        .tx_dst_x(tx_dst_x), .tx_dst_y(tx_dst_y), .tx_user(tx_user), .tx_len(tx_len),
        .tx_word_valid(tx_word_valid), .tx_word_ready(tx_word_ready), .tx_word(tx_word),
        .tx_phit_valid(tx_phit_valid), .tx_phit_ready(tx_phit_ready), .tx_phit(tx_phit),
        .rx_phit_valid(rx_phit_valid), .rx_phit_ready(rx_phit_ready), .rx_phit(rx_phit),
        .rx_hdr_valid(rx_hdr_valid), .rx_dst_x(rx_dst_x), .rx_dst_y(rx_dst_y),
        .rx_user(rx_user), .rx_len(rx_len),
        .rx_word_valid(rx_word_valid), .rx_word(rx_word), .rx_eom(rx_eom)
    );

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: sampled at the falling edge
    logic [15:0] phits [256];
    int          nphit = 0;
    logic [31:0] hdr_log [64];
    logic        hdr_eom [64];
    int          nhdr = 0;
    logic [31:0] w_log [128];
    logic        w_eom [128];
    int          nw = 0;
    int          pend = 0;
    int          r5_bad = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tx_msg_ready && nphit < pend) r5_bad++;
            if (tx_msg_valid && tx_msg_ready) pend += 2 * (int'(tx_len) + 1);
            if (tx_phit_valid && tx_phit_ready) begin
                phits[nphit] = tx_phit;
                nphit++;
            end
            if (rx_hdr_valid) begin
                hdr_log[nhdr] = {rx_dst_x, rx_dst_y, rx_user, rx_len};
                hdr_eom[nhdr] = rx_eom;
                nhdr++;
            end
            if (rx_word_valid) begin
                w_log[nw] = rx_word;
                w_eom[nw] = rx_eom;
                nw++;
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // stimulus table: {dst_x, dst_y, user, len, stall}
    localparam int NMSG = 6;
    localparam logic [32:0] VEC [NMSG] = '{
        {4'h3, 4'h5, 8'hA7, 16'd2, 1'b0},
        {4'hF, 4'hF, 8'hFF, 16'd0, 1'b0},
        {4'h0, 4'h0, 8'h00, 16'd1, 1'b1},
        {4'h9, 4'h2, 8'h3C, 16'd4, 1'b1},
        {4'h1, 4'hE, 8'h80, 16'd0, 1'b1},
        {4'h6, 4'h7, 8'h55, 16'd3, 1'b0}
    };

    function automatic logic [31:0] pay(input int m, input int i);
        return {8'(m), 8'hC3, 16'(i)} ^ 32'h5A00_0000;
    endfunction

    task automatic send_msg(input logic [31:0] h);
        @(negedge clk);
        {tx_dst_x, tx_dst_y, tx_user, tx_len} = h;
        tx_msg_valid = 1'b1;
        while (!tx_msg_ready) @(negedge clk);
        @(negedge clk);
        tx_msg_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        tx_word       = w;
        tx_word_valid = 1'b1;
        while (!tx_word_ready) @(negedge clk);
        @(negedge clk);
        tx_word_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 msg_ready in reset", 64'(tx_msg_ready), 64'd1);
        chk("R1 quiet outputs in reset",
            64'({tx_phit_valid, rx_hdr_valid, rx_word_valid, rx_eom}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", 64'({tx_msg_ready, tx_phit_valid, rx_hdr_valid, rx_word_valid}),
            64'b1000);

        for (int m = 0; m < NMSG; m++) begin
            logic [31:0] h;
            int len, p0, h0, w0, wait_c;
            h        = VEC[m][32:1];
            stall_en = VEC[m][0];
            len      = int'(h[15:0]);
            p0 = nphit; h0 = nhdr; w0 = nw;
            send_msg(h);
            for (int i = 0; i < len; i++) send_word(pay(m, i));
            wait_c = 0;
            while ((nhdr == h0 || nw < w0 + len || !tx_msg_ready) && wait_c < 300) begin
                @(negedge clk);
                wait_c++;
            end
            repeat (3) @(negedge clk);
            // R3: phit count and half order
            chk("R3 phit count", 64'(nphit - p0), 64'(2 * (len + 1)));
            chk("R3 low half first", 64'(phits[p0]), 64'(h[15:0]));
            // R2: header layout on link
            chk("R2 header flit", 64'({phits[p0+1], phits[p0]}), 64'(h));
            // R4 / R9: payload order on link, with stall for some entries
            for (int i = 0; i < len; i++)
                chk(stall_en ? "R9 payload under stall" : "R4 payload order",
                    64'({phits[p0+3+2*i], phits[p0+2+2*i]}), 64'(pay(m, i)));
            // R7: header delivered on rx
            chk("R7 header count", 64'(nhdr - h0), 64'd1);
            chk("R7 rx header fields", 64'(hdr_log[h0]), 64'(h));
            // R6 / R8: eom position and words
            if (len == 0) begin
                chk("R6 eom with header", 64'(hdr_eom[h0]), 64'd1);
                chk("R6 no words", 64'(nw - w0), 64'd0);
            end else begin
                chk("R8 no eom on header", 64'(hdr_eom[h0]), 64'd0);
                chk("R8 word count", 64'(nw - w0), 64'(len));
                for (int i = 0; i < len; i++) begin
                    chk("R8 rx word", 64'(w_log[w0+i]), 64'(pay(m, i)));
                    chk("R8 eom flag", 64'(w_eom[w0+i]), 64'(i == len - 1));
                end
            end
        end
        stall_en = 1'b0;
        // R5: ready never high while the packet was in flight
        chk("R5 ready low in flight", 64'(r5_bad), 64'd0);

        // R1: reset in mid-packet
        send_msg({4'h2, 4'h4, 8'h11, 16'd3});
        send_word(32'hDEAD_0001);
        @(negedge clk);
        chk("R1 busy before reset", 64'(tx_msg_ready), 64'd0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid-packet reset", 64'({tx_msg_ready, tx_phit_valid, rx_word_valid, rx_eom}),
            64'b1000);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule